// File: doc/BRIEF.md
# Shared-control down-counter timer bank

The block holds a bank of independent down-counters, eight by default, behind one word-addressed register port. Each counter has a read-only live count, a reload value and two compare values. All counters share one control word, and each counter owns a 4-bit field in it. The field turns the counter on, picks its count source, arms its wrap interrupt and holds a waveform-mode flag. The count source is either every bus clock cycle or only the cycles in which an external 1 MHz tick-enable input is high.

Software measures elapsed time by subtracting the live count from the reload value. It can also use a counter as a periodic interrupt source, because a counter that steps while at zero reloads itself. Each counter drives a sticky interrupt line and a one-cycle compare pulse.

The register port has no back-pressure. A write takes effect at the clock edge that samples it. A read is captured at the clock edge that samples the request and is presented on the data output from that edge onward.

Top module: `timer_bank`

## Requirements
- R1: Word addresses are laid out as follows. Timer n (1 to 3) occupies words 4(n-1) to 4(n-1)+3. Timer n (4 to 8) occupies words 16+4(n-4) to 16+4(n-4)+3. Within a timer the four words are, in order: live count, reload value, compare A, compare B. Word 12 is control word 1, and words 13 and 14 are plain read/write words. Word 15 reads as control word 1. Any other word reads as 0. Read data is registered: it appears one cycle after the request and holds until the next read.
- R2: Timer n uses control word 1 bits [4n-1:4n-4]. Within that field, bit 0 is enable, bit 1 selects the tick input as count source, bit 2 arms the wrap interrupt and bit 3 is the waveform-mode flag.
- R3: Only timers whose bit in PWM_CAPABLE is set store their bit 3. With the default 8'h0F that is timers 1 to 4. On the other timers bit 3 reads as 0 and ignores writes, so writing 0x88888888 to word 12 reads back 0x00008888.
- R4: Writing to word 15 clears each bit of control word 1 that is written as 1. Bits written as 0 keep their value.
- R5: While a timer is disabled, its live count is loaded with its reload value one cycle later. This also happens at the moment the timer is disabled.
- R6: While a timer is enabled with bit 1 set, its count drops by one in each cycle in which the tick input is high. In any other cycle the count holds.
- R7: While a timer is enabled with bit 1 clear, its count drops by one on every clock cycle.
- R8: When an enabled timer steps while its count is 0, the count is reloaded from the reload value. If bit 2 is set, the timer's interrupt output also goes high and stays high.
- R9: A timer's interrupt output is low in every cycle that follows a cycle in which its bit 2 is clear.
- R10: A timer's compare pulse is high for exactly the cycles in which its count has just stepped to a value equal to compare A or compare B. When the count does not step, no pulse is raised.
- R11: Bus writes to a live count word have no effect.
- R12: After reset, every register reads as 0, and every interrupt and compare pulse is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and count clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W (6) | Word address |
| bus_wdata | input | DW (32) | Write data |
| bus_rdata | output | DW (32) | Registered read data |
| tick_1mhz | input | 1 | 1 MHz tick enable, one cycle high per tick |
| irq | output | NUM_TMR (8) | Sticky wrap interrupt, one per timer |
| match_pulse | output | NUM_TMR (8) | One-cycle compare pulse, one per timer |

## Verification
The bench builds the block with its defaults: eight 32-bit timers, with only the first four able to store the waveform flag. This reaches both halves of the split address map and both the stored and the reserved flag bit. Timers in tick mode advance only when the bench raises the tick input, so every count, wrap and compare pulse falls in a cycle the bench knows in advance. Small reload values bring the wrap within a few cycles, and back-to-back reads of a clock-mode timer show it stepping on each cycle.

// File: rtl/timer_bank_pkg.sv
package timer_bank_pkg;

  // Active control bits handed to a channel (the waveform flag stays in the register file)
  typedef struct packed {
    logic ovf_ie;
    logic src_tick;
    logic en;
  } tmr_ctl_t;

  localparam int unsigned FLD_W      = 4;   // control bits per timer
  localparam int unsigned WORDS_PER  = 4;   // registers per timer
  localparam int unsigned LOW_GROUP  = 3;   // timers placed below the control words
  localparam int unsigned CTL1_WORD  = 12;
  localparam int unsigned CTL2_WORD  = 13;
  localparam int unsigned CTL3_WORD  = 14;
  localparam int unsigned CLR_WORD   = 15;
  localparam int unsigned HIGH_BASE  = 16;

  // First word address of timer i (0-based)
  function automatic int unsigned tmr_base(input int unsigned i);
    if (i < LOW_GROUP) return WORDS_PER * i;
    return HIGH_BASE + WORDS_PER * (i - LOW_GROUP);
  endfunction

endpackage

// File: rtl/timer_regfile.sv
module timer_regfile
  import timer_bank_pkg::*;
#(
  parameter int unsigned NUM_TMR     = 8,
  parameter int unsigned CNT_W       = 32,
  parameter int unsigned DW          = 32,
  parameter int unsigned ADDR_W      = 6,
  parameter logic [7:0]  PWM_CAPABLE = 8'h0F
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            bus_wr,
  input  logic                            bus_rd,
  input  logic [ADDR_W-1:0]               bus_addr,
  input  logic [DW-1:0]                   bus_wdata,
  output logic [DW-1:0]                   bus_rdata,
  input  logic [NUM_TMR-1:0][CNT_W-1:0]   live_cnt,
  output tmr_ctl_t [NUM_TMR-1:0]          ctl,
  output logic [NUM_TMR-1:0][CNT_W-1:0]   reload,
  output logic [NUM_TMR-1:0][CNT_W-1:0]   cmp_a,
  output logic [NUM_TMR-1:0][CNT_W-1:0]   cmp_b
);

  localparam int unsigned CTL_W = FLD_W * NUM_TMR;

  function automatic logic [CTL_W-1:0] ctl_wmask();
    logic [CTL_W-1:0] m;
    m = '0;
    for (int i = 0; i < int'(NUM_TMR); i++) begin
      m[FLD_W*i +: 3]   = 3'b111;
      m[FLD_W*i + 3]    = PWM_CAPABLE[i];
    end
    return m;
  endfunction

  localparam logic [CTL_W-1:0] CTL_WMASK = ctl_wmask();

  logic [CTL_W-1:0] ctl1_q;
  logic [DW-1:0]    ctl2_q, ctl3_q, rdata_q, rd_mux;

  function automatic logic hit(input logic [ADDR_W-1:0] a, input int unsigned w);
    return a == ADDR_W'(w);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl1_q <= '0;
      ctl2_q <= '0;
      ctl3_q <= '0;
      reload <= '0;
      cmp_a  <= '0;
      cmp_b  <= '0;
    end else if (bus_wr) begin
      if (hit(bus_addr, CTL1_WORD)) ctl1_q <= bus_wdata[CTL_W-1:0] & CTL_WMASK;
      if (hit(bus_addr, CLR_WORD))  ctl1_q <= ctl1_q & ~bus_wdata[CTL_W-1:0];
      if (hit(bus_addr, CTL2_WORD)) ctl2_q <= bus_wdata;
      if (hit(bus_addr, CTL3_WORD)) ctl3_q <= bus_wdata;
      for (int i = 0; i < int'(NUM_TMR); i++) begin
        // word tmr_base(i)+0 is the live count: not writable (R11)
        if (hit(bus_addr, tmr_base(i) + 1)) reload[i] <= bus_wdata[CNT_W-1:0];
        if (hit(bus_addr, tmr_base(i) + 2)) cmp_a[i]  <= bus_wdata[CNT_W-1:0];
        if (hit(bus_addr, tmr_base(i) + 3)) cmp_b[i]  <= bus_wdata[CNT_W-1:0];
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    if (hit(bus_addr, CTL1_WORD) || hit(bus_addr, CLR_WORD)) rd_mux = DW'(ctl1_q);
    if (hit(bus_addr, CTL2_WORD)) rd_mux = ctl2_q;
    if (hit(bus_addr, CTL3_WORD)) rd_mux = ctl3_q;
    for (int i = 0; i < int'(NUM_TMR); i++) begin
      if (hit(bus_addr, tmr_base(i)))     rd_mux = DW'(live_cnt[i]);
      if (hit(bus_addr, tmr_base(i) + 1)) rd_mux = DW'(reload[i]);
      if (hit(bus_addr, tmr_base(i) + 2)) rd_mux = DW'(cmp_a[i]);
      if (hit(bus_addr, tmr_base(i) + 3)) rd_mux = DW'(cmp_b[i]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      rdata_q <= '0;
    else if (bus_rd) rdata_q <= rd_mux;
  end

  assign bus_rdata = rdata_q;

  for (genvar g = 0; g < NUM_TMR; g++) begin : g_ctl
    assign ctl[g].en       = ctl1_q[FLD_W*g];
    assign ctl[g].src_tick = ctl1_q[FLD_W*g + 1];
    assign ctl[g].ovf_ie   = ctl1_q[FLD_W*g + 2];
  end

  // R4: every bit written as one to the clear alias is zero afterwards
  a_r4_clear_alias: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && hit(bus_addr, CLR_WORD)) |=> ((ctl1_q & $past(bus_wdata[CTL_W-1:0])) == '0));

  // R1: read data holds while no read is requested
  a_r1_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata));

endmodule

// File: rtl/timer_channel.sv
module timer_channel
  import timer_bank_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  tmr_ctl_t         ctl,
  input  logic             tick,
  input  logic [CNT_W-1:0] reload,
  input  logic [CNT_W-1:0] cmp_a,
  input  logic [CNT_W-1:0] cmp_b,
  output logic [CNT_W-1:0] cnt,
  output logic             irq,
  output logic             match_pulse
);

  logic [CNT_W-1:0] cnt_q, cnt_nx;
  logic             step, at_zero, irq_q, pulse_q;

  assign step    = ctl.en && (ctl.src_tick ? tick : 1'b1);
  assign at_zero = (cnt_q == '0);

  always_comb begin
    cnt_nx = cnt_q;
    if (!ctl.en)     cnt_nx = reload;
    else if (step)   cnt_nx = at_zero ? reload : cnt_q - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      irq_q   <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_nx;
      pulse_q <= step && ((cnt_nx == cmp_a) || (cnt_nx == cmp_b));
      if (!ctl.ovf_ie)           irq_q <= 1'b0;
      else if (step && at_zero)  irq_q <= 1'b1;
    end
  end

  assign cnt         = cnt_q;
  assign irq         = irq_q;
  assign match_pulse = pulse_q;

  // R5: a disabled timer takes its reload value
  a_r5_disabled_load: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl.en |=> (cnt == $past(reload)));

  // R6: tick mode without a tick holds the count
  a_r6_hold_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.en && ctl.src_tick && !tick) |=> $stable(cnt));

  // R8: stepping at zero reloads
  a_r8_wrap_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (step && at_zero) |=> (cnt == $past(reload)));

  // R9: interrupt low after a cycle with the arm bit clear
  a_r9_irq_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl.ovf_ie |=> !irq);

  // R10: no compare pulse without a step
  a_r10_pulse_needs_step: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> !match_pulse);

endmodule

// File: rtl/timer_bank.sv
module timer_bank
  import timer_bank_pkg::*;
#(
  parameter int unsigned NUM_TMR     = 8,
  parameter int unsigned CNT_W       = 32,
  parameter int unsigned DW          = 32,
  parameter int unsigned ADDR_W      = 6,
  parameter logic [7:0]  PWM_CAPABLE = 8'h0F
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DW-1:0]      bus_wdata,
  output logic [DW-1:0]      bus_rdata,
  input  logic               tick_1mhz,
  output logic [NUM_TMR-1:0] irq,
  output logic [NUM_TMR-1:0] match_pulse
);

  tmr_ctl_t [NUM_TMR-1:0]          ctl;
  logic [NUM_TMR-1:0][CNT_W-1:0]   live_cnt, reload, cmp_a, cmp_b;

  timer_regfile #(
    .NUM_TMR(NUM_TMR), .CNT_W(CNT_W), .DW(DW), .ADDR_W(ADDR_W), .PWM_CAPABLE(PWM_CAPABLE)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .live_cnt(live_cnt), .ctl(ctl),
    .reload(reload), .cmp_a(cmp_a), .cmp_b(cmp_b)
  );

  for (genvar g = 0; g < NUM_TMR; g++) begin : g_chan
    timer_channel #(.CNT_W(CNT_W)) u_chan (
      .clk(clk), .rst_n(rst_n), .ctl(ctl[g]), .tick(tick_1mhz),
      .reload(reload[g]), .cmp_a(cmp_a[g]), .cmp_b(cmp_b[g]),
      .cnt(live_cnt[g]), .irq(irq[g]), .match_pulse(match_pulse[g])
    );
  end

endmodule

// File: tb/tb_timer_bank.sv
module tb_timer_bank;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0, tick = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [7:0]  irq, match_pulse;

  int checks = 0, failures = 0, mcount = 0;
  bit done = 1'b0, raw_mode = 1'b0, pend = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  timer_bank dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick_1mhz(tick), .irq(irq),
    .match_pulse(match_pulse)
  );

  always #10 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops the scoreboard one cycle after each read request
  always @(posedge clk) pend <= bus_rd;
  always @(negedge clk) begin
    if (pend && !raw_mode && exp_q.size() > 0)
      check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
    if (match_pulse[1]) mcount++;
  end

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = 6'(a); bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
    @(negedge clk);
  endtask

  task automatic rd(input int a, input logic [31:0] e, input string tag);
    @(negedge clk); exp_q.push_back(e); tag_q.push_back(tag);
    bus_rd = 1'b1; bus_addr = 6'(a);
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
    @(negedge clk);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] v1, v2;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    check("R12 irq", 32'(irq), 0);
    check("R12 match", 32'(match_pulse), 0);
    rd(12, 0, "R12 ctrl1");
    rd(0, 0, "R12 t1 count");
    // R1 map
    rd(40, 0, "R1 unmapped");
    wr(17, 32'h1234);
    wr(35, 32'hCAFE0001);
    wr(13, 32'hA5A5A5A5);
    rd(17, 32'h1234, "R1 t4 reload");
    rd(35, 32'hCAFE0001, "R1 t8 cmpB");
    rd(13, 32'hA5A5A5A5, "R1 ctrl2");
    rd(16, 32'h1234, "R5 t4 count follows reload");
    // R3 reserved waveform bit
    wr(12, 32'h88888888);
    rd(12, 32'h00008888, "R3 pwm bits");
    rd(15, 32'h00008888, "R1 alias reads ctrl1");
    wr(12, 0);
    // R6 / R8 / R11 tick mode on timer 1
    wr(1, 3);
    wr(12, 32'h7);
    rd(0, 3, "R6 t1 start");
    wr(0, 32'h55);
    rd(0, 3, "R11 count not writable");
    ticks(2);
    rd(0, 1, "R6 two ticks");
    check("R8 irq before wrap", 32'(irq[0]), 0);
    ticks(2);
    rd(0, 3, "R8 wrap reload");
    check("R8 irq after wrap", 32'(irq[0]), 1);
    ticks(1);
    check("R8 irq sticky", 32'(irq[0]), 1);
    // R4 / R9
    wr(15, 32'h4);
    rd(12, 32'h3, "R4 clear alias");
    check("R9 irq cleared", 32'(irq[0]), 0);
    ticks(3);
    rd(0, 3, "R9 wrap without arm");
    check("R9 irq stays low", 32'(irq[0]), 0);
    // R5 disable loads reload
    ticks(1);
    rd(0, 2, "R6 one tick");
    wr(15, 32'h1);
    rd(0, 3, "R5 disable loads");
    wr(1, 9);
    rd(0, 9, "R5 follows reload");
    // R7 clock mode on timer 2
    wr(5, 1000);
    wr(12, 32'h12);
    raw_mode = 1'b1;
    @(negedge clk); bus_rd = 1'b1; bus_addr = 6'd4;
    @(negedge clk); v1 = bus_rdata;
    @(negedge clk); v2 = bus_rdata; bus_rd = 1'b0;
    @(negedge clk); @(negedge clk);
    raw_mode = 1'b0;
    check("R7 step per cycle", v2, v1 - 1);
    check("R7 counting", 32'(v1 < 1000 && v1 > 900), 1);
    wr(12, 32'h02);
    // R10 compare pulses on timer 2
    wr(5, 8); wr(6, 5); wr(7, 2);
    mcount = 0;
    wr(12, 32'h32);
    rd(4, 8, "R10 start");
    ticks(3);
    check("R10 pulse at cmpA", mcount, 1);
    check("R10 pulse one cycle", 32'(match_pulse[1]), 0);
    ticks(3);
    check("R10 pulse at cmpB", mcount, 2);
    ticks(1);
    check("R10 no pulse off match", mcount, 2);
    rd(4, 1, "R10 count");
    // R2 field position of timer 8, clock mode, armed
    wr(33, 2);
    wr(12, 32'h50000000);
    repeat (10) @(negedge clk);
    check("R2 t8 field irq", 32'(irq), 32'h80);
    rd(12, 32'h50000000, "R2 ctrl readback");
    wr(12, 0);
    check("R9 irq all low", 32'(irq), 0);
    @(negedge clk); @(negedge clk);
    check("R1 scoreboard drained", exp_q.size(), 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule